// File: doc/BRIEF.md
# Sensor Count to Temperature Converter

This block turns a raw count from an on-die temperature sensor into a signed temperature in millidegrees Celsius. A linear calibration maps the count to temperature, and a frequency-dependent correction term is added. Every coefficient is an input, so one instance serves sensors of different calibration families. The result is then saturated to an industrial operating window.

A caller presents the sample word, the coefficients and the sensor clock frequency in hertz, and pulses `start_i` for one cycle. The block latches every operand and performs two long divisions on one shared radix-2 restoring divider, one quotient bit per cycle. It then forms the sum, saturates it, and presents the result with a one-cycle `done_o` pulse. The result and the error flag hold their values until the next conversion completes.

Two calibration sets are typical. The first is H=200000, G=60000, J=-100, cal5=4094. The second is H=249400, G=57400, J=0, cal5=4096.

Top module: `sensor_temp_conv`

## Requirements
- R1: Only the low 16 bits of `sample_i` form the count n. Bits 31:16 have no effect on the result.
- R2: For a nonzero cal5, the result is G + trunc(H*n/cal5) - floor(H/2) + trunc(J*F/1000000). H, G, cal5 and F are unsigned and J is signed. Both divisions truncate toward zero, and the sum is formed with 64-bit signed precision.
- R3: The presented result is saturated to the inclusive range -40000 to 125000.
- R4: A conversion with cal5 equal to zero presents 125000 with `err_o` high. A conversion with a nonzero cal5 presents `err_o` low.
- R5: Each accepted start produces exactly one `done_o` pulse, one cycle wide. `result_o` and `err_o` change only in the cycle in which `done_o` is high.
- R6: A start while a conversion is in progress is ignored. It produces no extra `done_o`, and it does not alter the result of the running conversion.
- R7: After reset, `done_o`, `err_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert the presented operands |
| sample_i | input | 32 | Sensor sample word; the count is bits 15:0 |
| coef_h_i | input | 32 | Unsigned slope coefficient H |
| coef_g_i | input | 32 | Unsigned offset coefficient G |
| coef_cal5_i | input | 32 | Unsigned count divisor cal5 |
| coef_j_i | input | 32 | Signed frequency coefficient J |
| freq_hz_i | input | 32 | Sensor clock frequency F in hertz |
| done_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | 32 | Signed temperature in millidegrees Celsius |
| err_o | output | 1 | High when the last conversion had cal5 equal to zero |

## Verification
The divider checks assume that a zero divisor never reaches them. This holds because the controller steers a zero cal5 straight to the saturated error result. The divider checks also assume that a divider start is never issued while the divider is busy.

The output checks assume that the sum always fits in 64 bits. The operand widths guarantee this for any input values, so the stimulus can use extreme coefficients. Those include H and cal5 at all ones and J at its most negative value.

The bench holds `start_i` high for a single cycle. It waits for each result before issuing the next request, except in the deliberate mid-conversion start.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_CNT,
    ST_DIV_FRQ,
    ST_SUM
  } tconv_state_e;

  localparam int unsigned HZ_PER_MHZ = 1000000;
endpackage

// File: rtl/tconv_div.sv
module tconv_div #(
  parameter int DVD_W = 64,
  parameter int DSR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic [DVD_W-1:0] quot_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DSR_W:0]   rem_q;
  logic [DVD_W-1:0] quo_q;
  logic [DSR_W-1:0] dsr_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DSR_W:0]   shifted;
  logic [DSR_W+1:0] trial;
  logic             neg;

  always_comb begin
    shifted = {rem_q[DSR_W-1:0], quo_q[DVD_W-1]};
    trial   = {1'b0, shifted} - {2'b00, dsr_q};
    neg     = trial[DSR_W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dsr_q  <= divisor_i;
        cnt_q  <= CNT_W'(DVD_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= neg ? shifted : trial[DSR_W:0];
        quo_q <= {quo_q[DVD_W-2:0], ~neg};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

  // R2: a finished division leaves a remainder below the divisor
  assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rem_q < {1'b0, dsr_q}));

  // R6: the controller never restarts the divider mid-division
  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o);
endmodule

// File: rtl/tconv_sat.sv
module tconv_sat #(
  parameter int     IN_W  = 64,
  parameter int     OUT_W = 32,
  parameter longint LO    = -40000,
  parameter longint HI    = 125000
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam logic signed [IN_W-1:0] LO_X = IN_W'(LO);
  localparam logic signed [IN_W-1:0] HI_X = IN_W'(HI);

  always_comb begin
    if (val_i < LO_X)      val_o = OUT_W'(LO_X);
    else if (val_i > HI_X) val_o = OUT_W'(HI_X);
    else                   val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/sensor_temp_conv.sv
module sensor_temp_conv
  import tconv_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int COUNT_W  = 16,
  parameter int COEF_W   = 32,
  parameter int RES_W    = 32,
  parameter int T_MIN    = -40000,
  parameter int T_MAX    = 125000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [COEF_W-1:0]       coef_h_i,
  input  logic [COEF_W-1:0]       coef_g_i,
  input  logic [COEF_W-1:0]       coef_cal5_i,
  input  logic signed [COEF_W-1:0] coef_j_i,
  input  logic [COEF_W-1:0]       freq_hz_i,
  output logic                    done_o,
  output logic signed [RES_W-1:0] result_o,
  output logic                    err_o
);
  localparam int DVD_W = 2 * COEF_W;

  tconv_state_e state_q;
  logic [COEF_W-1:0]        h_q, g_q, f_q;
  logic signed [COEF_W-1:0] j_q;
  logic                     zero_q;
  logic [DVD_W-1:0]         q_cnt_q;
  logic signed [DVD_W-1:0]  q_frq_q;

  logic                     div_start_q;
  logic [DVD_W-1:0]         div_dvd_q;
  logic [COEF_W-1:0]        div_dsr_q;
  logic [DVD_W-1:0]         div_quot;
  logic                     div_done, div_busy;

  logic                     j_neg;
  logic [COEF_W-1:0]        j_mag;
  logic signed [DVD_W-1:0]  sum_w;
  logic signed [RES_W-1:0]  sat_w;

  tconv_div #(.DVD_W(DVD_W), .DSR_W(COEF_W)) div_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (div_start_q),
    .dividend_i(div_dvd_q),
    .divisor_i (div_dsr_q),
    .quot_o    (div_quot),
    .done_o    (div_done),
    .busy_o    (div_busy)
  );

  always_comb begin
    j_neg = j_q[COEF_W-1];
    j_mag = j_neg ? (~j_q + 1'b1) : j_q;
    sum_w = $signed(DVD_W'(g_q)) + $signed(q_cnt_q)
          - $signed(DVD_W'(h_q >> 1)) + q_frq_q;
  end

  tconv_sat #(.IN_W(DVD_W), .OUT_W(RES_W), .LO(T_MIN), .HI(T_MAX)) sat_i (
    .val_i(sum_w),
    .val_o(sat_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      h_q         <= '0;
      g_q         <= '0;
      f_q         <= '0;
      j_q         <= '0;
      zero_q      <= 1'b0;
      q_cnt_q     <= '0;
      q_frq_q     <= '0;
      div_start_q <= 1'b0;
      div_dvd_q   <= '0;
      div_dsr_q   <= '0;
      done_o      <= 1'b0;
      result_o    <= '0;
      err_o       <= 1'b0;
    end else begin
      div_start_q <= 1'b0;
      done_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          h_q    <= coef_h_i;
          g_q    <= coef_g_i;
          j_q    <= coef_j_i;
          f_q    <= freq_hz_i;
          zero_q <= (coef_cal5_i == '0);
          if (coef_cal5_i == '0) begin
            state_q <= ST_SUM;
          end else begin
            div_start_q <= 1'b1;
            div_dvd_q   <= DVD_W'(coef_h_i) * DVD_W'(sample_i[COUNT_W-1:0]);
            div_dsr_q   <= coef_cal5_i;
            state_q     <= ST_DIV_CNT;
          end
        end
        ST_DIV_CNT: if (div_done) begin
          q_cnt_q     <= div_quot;
          div_start_q <= 1'b1;
          div_dvd_q   <= DVD_W'(j_mag) * DVD_W'(f_q);
          div_dsr_q   <= COEF_W'(HZ_PER_MHZ);
          state_q     <= ST_DIV_FRQ;
        end
        ST_DIV_FRQ: if (div_done) begin
          q_frq_q <= j_neg ? -$signed(div_quot) : $signed(div_quot);
          state_q <= ST_SUM;
        end
        ST_SUM: begin
          result_o <= zero_q ? RES_W'(T_MAX) : sat_w;
          err_o    <= zero_q;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: every presented result lies inside the window
  assert_result_window_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o >= T_MIN && result_o <= T_MAX));

  // R4: an error result is the upper bound
  assert_err_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (result_o == RES_W'(T_MAX)));

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: outputs hold between completions
  assert_output_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(err_o)));
endmodule

// File: tb/sensor_temp_conv_tb.sv
module sensor_temp_conv_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] sample_i = '0, coef_h_i = '0, coef_g_i = '0, coef_cal5_i = '0, freq_hz_i = '0;
  logic signed [31:0] coef_j_i = '0;
  logic done_o, err_o;
  logic signed [31:0] result_o;

  int checks = 0;
  int fails = 0;
  int dones = 0;

  typedef struct {
    longint res;
    bit     err;
    string  tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  sensor_temp_conv dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sample_i(sample_i),
    .coef_h_i(coef_h_i), .coef_g_i(coef_g_i), .coef_cal5_i(coef_cal5_i),
    .coef_j_i(coef_j_i), .freq_hz_i(freq_hz_i),
    .done_o(done_o), .result_o(result_o), .err_o(err_o)
  );

  function automatic longint model(longint n, longint h, longint g, longint c,
                                   longint j, longint f, output bit e);
    longint t;
    if (c == 0) begin
      e = 1'b1;
      return 125000;
    end
    e = 1'b0;
    t = g + (h * n) / c - h / 2 + (j * f) / 1000000;
    if (t < -40000) t = -40000;
    if (t > 125000) t = 125000;
    return t;
  endfunction

  // monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (!rst && done_o) begin
      dones++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5/R6 unexpected done: result=%0d expected=no completion", result_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (longint'(result_o) != e.res) begin
          fails++;
          $display("FAIL %s result: actual=%0d expected=%0d", e.tag, result_o, e.res);
        end
        if (err_o != e.err) begin
          fails++;
          $display("FAIL %s err flag: actual=%0d expected=%0d", e.tag, err_o, e.err);
        end
      end
    end
  end

  task automatic pulse_start(input logic [31:0] s, h, g, c, input int j, input logic [31:0] f);
    @(negedge clk);
    sample_i = s; coef_h_i = h; coef_g_i = g; coef_cal5_i = c; coef_j_i = j; freq_hz_i = f;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic convert(input logic [31:0] s, h, g, c, input int j,
                         input logic [31:0] f, input string tag);
    exp_t e;
    bit eb;
    e.res = model(longint'(s[15:0]), longint'(h), longint'(g), longint'(c),
                  longint'(j), longint'(f), eb);
    e.err = eb;
    e.tag = tag;
    exp_q.push_back(e);
    pulse_start(s, h, g, c, j, f);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    checks++;
    if (done_o !== 1'b0 || err_o !== 1'b0 || result_o !== 32'sd0) begin
      fails++;
      $display("FAIL R7 reset: actual=%0d/%0d/%0d expected=0/0/0", done_o, err_o, result_o);
    end

    convert(32'd2047, 200000, 60000, 4094, -100, 100000000, "R2 default mid");
    convert(32'd0,    200000, 60000, 4094, -100, 100000000, "R3 low clamp");
    convert(32'd4094, 200000, 60000, 4094, -100, 100000000, "R3 high clamp");
    convert(32'd1000, 249400, 57400, 4096, 0, 0, "R2 alternate set");
    convert(32'hABCD_07FF, 200000, 60000, 4094, -100, 100000000, "R1 upper bits ignored");
    convert(32'd1, 1000, 0, 3, -7, 1500000, "R2 truncate negative J");
    convert(32'd2, 1000, 0, 3, 7, 1500000, "R2 truncate positive J");
    convert(32'd5, 0, 10000, 9, 32'h8000_0000, 1, "R2 most negative J");
    convert(32'hFFFF, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 0, "R3 extreme operands");
    convert(32'd2047, 200000, 60000, 0, -100, 100000000, "R4 zero cal5");
    convert(32'd2047, 200000, 60000, 4094, -100, 100000000, "R4 error clears");

    // R6: second start mid-conversion must be ignored
    d0 = dones;
    begin
      exp_t e;
      bit eb;
      e.res = model(2047, 200000, 60000, 4094, -100, 100000000, eb);
      e.err = eb;
      e.tag = "R6 busy start ignored";
      exp_q.push_back(e);
    end
    pulse_start(32'd2047, 200000, 60000, 4094, -100, 100000000);
    repeat (5) @(negedge clk);
    pulse_start(32'd4094, 249400, 0, 0, 0, 0);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
    checks++;
    if (dones - d0 != 1) begin
      fails++;
      $display("FAIL R6 completions: actual=%0d expected=1", dones - d0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule